// File: doc/BRIEF.md
# Two-Wire Bus High-Speed Mode Entry Tracker

This block listens passively to a two-wire serial bus (clock line and data line) from the slave side. It works out whether the bus is using its normal Fast/Standard signalling or its high-speed signalling. The line levels arrive asynchronously. A two-flop synchroniser per line resynchronises them to a system clock that runs at least eight times the fastest bit rate. After that stage the block recognises bus conditions: START, repeated START (Sr) and STOP. It then shifts in the first byte of each transfer on clock-line rising edges.

A master announces high-speed traffic in three steps. It opens with a START and sends a reserved master-code byte. That byte must go unacknowledged. The block watches for this pattern. The repeated START that follows switches the bus to high-speed signalling. The bus stays in high-speed signalling across any number of further repeated STARTs and leaves it only on a STOP. Two outputs report this:
- A flag that says the bus is in high-speed signalling.
- A select that picks the input-qualification timing for the surrounding pad logic. This select moves one clock ahead of the flag on entry, and on the STOP clock itself on exit.

The block also decodes the 7-bit slave address and the read/write bit carried by each address byte.

Top module: `hs_entry_tracker`

## Requirements
- R1: A START or repeated START is the synchronised data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. Data-line changes while the clock line is low create no condition and change no output.
- R2: The first byte after a START from an idle bus is checked for a master code. Bits are taken on clock-line rising edges, MSB first. The byte is a master code when its bits 7:3 equal 00001; bits 2:0 are ignored. A master code is not reported as an address.
- R3: A master code is followed by a ninth-clock slot. When the data line is high in that slot (not acknowledged), the block arms. The next repeated START then sets `hs_active`, which rises one clock after that repeated START is detected.
- R4: When the master code is acknowledged instead (data line low in the ninth slot), the block does not arm. The following repeated START leaves `hs_active` low.
- R5: Once set, `hs_active` stays high across any number of further repeated STARTs and the transfers between them.
- R6: A STOP clears `hs_active` and any armed state on the next clock. `filt_sel_hs` is low in the very cycle the STOP is detected.
- R7: `filt_sel_hs` goes high in the cycle the entering repeated START is detected, one clock before `hs_active`. After that it tracks `hs_active`.
- R8: The first byte after a START or repeated START that is not a master code is decoded as follows. `addr` takes byte bits 7:1 and `addr_rw` takes bit 0. `addr_valid` pulses for one clock. This holds in both signalling modes, and `addr`/`addr_rw` hold their values until the next address byte.
- R9: A byte matching the master-code pattern that follows a repeated START is decoded as an address, not a master code. It never arms high-speed entry.
- R10: After reset, `hs_active`, `filt_sel_hs`, `addr`, `addr_rw` and `addr_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line level (asynchronous) |
| sda_in | input | 1 | Bus data line level (asynchronous) |
| hs_active | output | 1 | High while the bus is in high-speed signalling |
| filt_sel_hs | output | 1 | Input-filter timing select: 1 = high-speed setting |
| addr | output | 7 | Last decoded slave address |
| addr_rw | output | 1 | Read/write bit of the last address byte |
| addr_valid | output | 1 | One-clock pulse when an address byte completes |

## Verification
A line change driven before clock edge k is caught by the synchroniser at edge k. A bus condition it forms is visible to the decode logic during the cycle after edge k+1. `filt_sel_hs` therefore changes in that cycle. `hs_active`, `addr`, `addr_rw` and `addr_valid` change one edge later, after edge k+2. The bench keeps a three-deep history of the line levels it applied at each edge and steps a behavioural protocol model from the two older entries, mirroring that delay. It then compares every output on the falling edge of each clock, half a cycle after the registers settle. Scenario checks at the end of each bus phase add literal expectations for entry, chaining, exit, the acknowledged master code and the master code after a repeated START.

// File: rtl/hs_entry_tracker.sv
module hs_entry_tracker #(
  parameter logic [4:0] MC_PREFIX = 5'b00001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       hs_active,
  output logic       filt_sel_hs,
  output logic [6:0] addr,
  output logic       addr_rw,
  output logic       addr_valid
);

  localparam logic [3:0] LAST_DATA = 4'd7;
  localparam logic [3:0] ACK_SLOT  = 4'd8;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end
  end

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];

  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;

  logic       busy, first_byte, from_start;
  logic       mc_pend, armed, hs_q;
  logic [3:0] bitcnt;
  logic [7:0] shreg;

  wire [7:0] byte_nx  = {shreg[6:0], sda_s};
  wire       enter_hs = start_det & busy & armed;
  wire       is_mc    = from_start & ~hs_q & (byte_nx[7:3] == MC_PREFIX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      first_byte <= 1'b0;
      from_start <= 1'b0;
      mc_pend    <= 1'b0;
      armed      <= 1'b0;
      hs_q       <= 1'b0;
      bitcnt     <= '0;
      shreg      <= '0;
      addr       <= '0;
      addr_rw    <= 1'b0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= 1'b0;
      if (stop_det) begin
        busy       <= 1'b0;
        first_byte <= 1'b0;
        mc_pend    <= 1'b0;
        armed      <= 1'b0;
        hs_q       <= 1'b0;
        bitcnt     <= '0;
      end else if (start_det) begin
        busy       <= 1'b1;
        first_byte <= 1'b1;
        from_start <= ~busy;
        mc_pend    <= 1'b0;
        bitcnt     <= '0;
        if (!busy) begin
          hs_q  <= 1'b0;
          armed <= 1'b0;
        end else if (armed) begin
          hs_q  <= 1'b1;
          armed <= 1'b0;
        end
      end else if (scl_rise && busy) begin
        if (bitcnt != ACK_SLOT) begin
          shreg  <= byte_nx;
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == LAST_DATA && first_byte) begin
            if (is_mc) begin
              mc_pend <= 1'b1;
            end else begin
              addr       <= byte_nx[7:1];
              addr_rw    <= byte_nx[0];
              addr_valid <= 1'b1;
            end
          end
        end else begin
          bitcnt     <= '0;
          first_byte <= 1'b0;
          mc_pend    <= 1'b0;
          if (mc_pend) armed <= sda_s;
        end
      end
    end
  end

  assign hs_active   = hs_q;
  assign filt_sel_hs = (hs_q | enter_hs) & ~stop_det;

  assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= ACK_SLOT);

  assert_arm_needs_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(mc_pend && scl_rise && sda_s));

  assert_hs_entry_from_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_active) |-> $past(armed && start_det));

  assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!hs_active && !armed));

  assert_filt_low_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |-> !filt_sel_hs);

  assert_mc_only_in_fs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mc_pend) |-> (!hs_active && from_start));

  assert_addr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> !addr_valid);

endmodule

// File: tb/test_hs_entry_tracker.sv
module test_hs_entry_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic hs_active, filt_sel_hs, addr_rw, addr_valid;
  logic [6:0] addr;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_entry_tracker i_hs_entry_tracker (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_drv),
    .hs_active(hs_active), .filt_sel_hs(filt_sel_hs),
    .addr(addr), .addr_rw(addr_rw), .addr_valid(addr_valid));

  // behavioural protocol model
  int hc[3], hd[3];
  int m_busy, m_first, m_fs, m_mcp, m_arm, m_hs, m_bits, m_byte;
  int m_addr, m_rw, m_av;

  task automatic check(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin hc[i] = 1; hd[i] = 1; end
      m_busy = 0; m_first = 0; m_fs = 0; m_mcp = 0; m_arm = 0; m_hs = 0;
      m_bits = 0; m_byte = 0; m_addr = 0; m_rw = 0; m_av = 0;
    end else begin
      int nc, nd, oc, od;
      nc = hc[1]; nd = hd[1]; oc = hc[2]; od = hd[2];
      m_av = 0;
      if (nc && oc && !od && nd) begin
        m_busy = 0; m_hs = 0; m_arm = 0; m_mcp = 0; m_bits = 0; m_first = 0;
      end else if (nc && oc && od && !nd) begin
        if (m_busy == 0) begin m_hs = 0; m_arm = 0; m_fs = 1; end
        else begin
          m_fs = 0;
          if (m_arm) begin m_hs = 1; m_arm = 0; end
        end
        m_busy = 1; m_first = 1; m_bits = 0; m_mcp = 0;
      end else if (nc && !oc && m_busy) begin
        if (m_bits < 8) begin
          m_byte = (m_byte * 2 + nd) % 256;
          m_bits++;
          if (m_bits == 8 && m_first) begin
            if (m_fs && !m_hs && (m_byte / 8) == 1) m_mcp = 1;
            else begin m_addr = m_byte / 2; m_rw = m_byte % 2; m_av = 1; end
          end
        end else begin
          m_bits = 0; m_first = 0;
          if (m_mcp) m_arm = nd;
          m_mcp = 0;
        end
      end
      hc[2] = hc[1]; hd[2] = hd[1];
      hc[1] = hc[0]; hd[1] = hd[0];
      hc[0] = scl_drv; hd[0] = sda_drv;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int sr, sp, ef;
      sr = hc[1] && hc[2] && hd[2] && !hd[1] && m_busy;
      sp = hc[1] && hc[2] && !hd[2] && hd[1];
      ef = (m_hs || (sr && m_arm)) && !sp;
      check("R5 hs_active model", hs_active, m_hs);
      check("R7 filt_sel_hs model", filt_sel_hs, ef);
      check("R8 addr_valid model", addr_valid, m_av);
      check("R8 addr model", addr, m_addr);
      check("R8 addr_rw model", addr_rw, m_rw);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired got=%0d exp=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask
  task automatic put(input logic c, input logic d);
    scl_drv = c; sda_drv = d; wq();
  endtask
  task automatic b_start();
    put(1, 1); put(1, 0); put(0, 0);
  endtask
  task automatic b_rstart();
    put(0, 1); put(1, 1); put(1, 0); put(0, 0);
  endtask
  task automatic b_stop();
    put(0, 0); put(1, 0); put(1, 1);
  endtask
  task automatic b_bit(input logic b);
    put(0, b); put(1, b); put(0, b);
  endtask
  task automatic b_byte(input logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) b_bit(v[i]);
    b_bit(nack);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R10 reset hs_active", hs_active, 0);
    check("R10 reset filt_sel_hs", filt_sel_hs, 0);
    check("R10 reset addr", addr, 0);
    check("R10 reset addr_rw", addr_rw, 0);
    check("R10 reset addr_valid", addr_valid, 0);
    rst_n = 1'b1;
    wq();

    // plain address: no HS entry
    b_start();
    b_byte(8'h50, 1'b0);
    check("R8 plain addr", addr, 7'h28);
    check("R8 plain rw", addr_rw, 0);
    check("R2 plain address no hs", hs_active, 0);
    b_stop();

    // master code, NACK, Sr enters HS; chained Sr; STOP exit
    b_start();
    b_byte(8'h0B, 1'b1);
    check("R3 armed but not yet hs", hs_active, 0);
    check("R2 master code not an address", addr, 7'h28);
    b_rstart();
    check("R3 hs after Sr", hs_active, 1);
    check("R7 filt after Sr", filt_sel_hs, 1);
    b_byte(8'hA1, 1'b0);
    check("R8 hs addr", addr, 7'h50);
    check("R8 hs rw", addr_rw, 1);
    put(0, 1); put(0, 0); put(0, 1); put(0, 0);
    check("R1 sda toggles with scl low", hs_active, 1);
    b_byte(8'h08, 1'b0);
    b_rstart();
    check("R5 hs after chained Sr", hs_active, 1);
    b_byte(8'h11, 1'b0);
    check("R8 chained addr", addr, 7'h08);
    b_rstart();
    check("R5 hs after second chained Sr", hs_active, 1);
    b_byte(8'h22, 1'b1);
    b_stop();
    check("R6 hs cleared by stop", hs_active, 0);
    check("R6 filt cleared by stop", filt_sel_hs, 0);

    // master code acknowledged: no entry
    b_start();
    b_byte(8'h0F, 1'b0);
    b_rstart();
    check("R4 acked master code no hs", hs_active, 0);
    check("R4 acked master code filt", filt_sel_hs, 0);
    b_byte(8'h44, 1'b0);
    check("R4 addr after acked code", addr, 7'h22);
    b_stop();

    // master-code pattern after Sr is an address
    b_start();
    b_byte(8'h20, 1'b0);
    b_rstart();
    b_byte(8'h09, 1'b1);
    check("R9 pattern after Sr addr", addr, 7'h04);
    check("R9 pattern after Sr rw", addr_rw, 1);
    b_rstart();
    check("R9 no hs after Sr pattern", hs_active, 0);
    b_stop();
    wq();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule